// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block sits between a clock synthesizer's internal sources and its output drivers. It gates two families of output clocks: a group of fast processor clocks and a group of slower bus clocks. Three active-low asynchronous requests drive the gating: processor-clock stop, bus-clock stop and power-down. One bus-clock output is free running and never gated. A reference output is stopped only in power-down. The block also drives the enables for the crystal oscillator and the VCO.

Each family has its own gate controller, with these states:
- `G_HALT`: forced off by power-down, or waiting for the wake-up release.
- `G_MIN`: running inside the minimum-enable window.
- `G_RUN`: running and stoppable.
- `G_STOP`: stopped on request.

The transitions are:
- HALT→MIN or HALT→STOP when the force is released.
- MIN→RUN or MIN→STOP when the window ends. A stop that arrives during the window is held until then.
- RUN→STOP on a stop request.
- STOP→MIN on release.
- Any state→HALT on force.

The gate enable is re-registered on the falling edge of its source clock. An output can therefore change only while its source is low.

A power sequencer runs on the reference clock, with these states:
- `P_WAKE`: oscillator up, counting the stabilization period.
- `P_RUN`: clocks released.
- `P_PARK`: waiting for both families to report parked low.
- `P_OFF`: oscillator, VCO and reference output stopped.

The transitions are:
- WAKE→RUN when the count completes.
- WAKE→PARK or RUN→PARK on power-down.
- PARK→OFF once both families are parked.
- OFF→WAKE on release.

Reset enters `P_WAKE`.

Top module: `clkstop_ctrl`

## Requirements
- R1: Gated processor and bus outputs change only while their source clock is low. Every high pulse they emit is a full source half-period, and a stopped output is held low.
- R2: When the processor stop input falls during a low phase of the processor source clock, exactly three more processor pulses appear and the outputs then stay low. When the input rises during a low phase, the first pulse appears on the fourth processor source rising edge.
- R3: After a restart, the processor outputs emit at least CPU_MIN_ON pulses before a stop takes effect. A stop that arrives inside that window is held and applied when the window ends, which gives exactly CPU_MIN_ON pulses.
- R4: With the default of zero synchronizer stages, the bus stop input is sampled on the bus source rising edge. The edge that samples a stop still passes its pulse and no later pulse is emitted. The edge that samples a release passes nothing, and pulses resume on the next edge.
- R5: After a bus restart, the bus outputs emit at least PCI_MIN_ON pulses. A stop that arrives earlier is held, which gives exactly PCI_MIN_ON pulses.
- R6: A bus stop leaves the processor outputs, the free-running bus output and the reference output running. A processor stop leaves the bus outputs running.
- R7: On power-down, each family emits at most three more pulses of its own source clock. The oscillator and VCO enables (active high) fall only after both families are parked low. The reference output stops after the enables fall.
- R8: While power-down is low, both stop inputs have no effect, and no gated pulse appears whatever they do.
- R9: After reset release, and after power-down is released, the oscillator and VCO enables are high. The gated outputs stay low for at least STAB_CYCLES reference cycles and then resume.
- R10: During reset, all gated outputs are low and the oscillator and VCO enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_in | input | 1 | Processor source clock |
| pci_clk_in | input | 1 | Bus source clock |
| ref_clk_in | input | 1 | Reference source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_stop_n | input | 1 | Processor clock stop request, active low, asynchronous |
| pci_stop_n | input | 1 | Bus clock stop request, active low |
| pwr_dn_n | input | 1 | Power-down request, active low, asynchronous |
| cpu_clk_out | output | N_CPU | Gated processor clocks |
| pci_clk_out | output | N_PCI | Gated bus clocks |
| pci_free_out | output | 1 | Free-running bus clock |
| ref_out | output | 1 | Reference clock output |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |

## Verification
A gate controller stuck in a wrong state shows within one source clock as a missing or extra pulse. The bench therefore counts pulses against exact expected counts around every request edge. A fault in the minimum-enable counter shows only as a wrong total after a restart, about CPU_MIN_ON or PCI_MIN_ON cycles later. A power sequencer error appears at the ports in one of three ways:
- enables falling while a family still pulses;
- a reference output that keeps running;
- clocks resuming before the stabilization period ends.

The last of these can take STAB_CYCLES reference cycles to show.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic [1:0] {
        G_HALT = 2'd0,
        G_MIN  = 2'd1,
        G_RUN  = 2'd2,
        G_STOP = 2'd3
    } gate_state_t;

    typedef enum logic [1:0] {
        P_WAKE = 2'd0,
        P_RUN  = 2'd1,
        P_PARK = 2'd2,
        P_OFF  = 2'd3
    } pwr_state_t;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            // Input already synchronous to the consumer; the consumer's state register samples it.
            logic unused_pins;
            assign unused_pins = clk ^ rst_n;
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= {STAGES{RST_VAL}};
                end else begin
                    stage_q[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        stage_q[i] <= stage_q[i-1];
                    end
                end
            end
            assign q = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int MIN_ON = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic force_off,
    output logic gate_en,
    output logic parked
);

    localparam int CW = $clog2(MIN_ON + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_ON - 1);

    gate_state_t state, state_nx;
    logic [CW-1:0] win_cnt, win_cnt_nx;
    logic run_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= G_HALT;
            win_cnt <= '0;
        end else begin
            state   <= state_nx;
            win_cnt <= win_cnt_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx   = state;
        win_cnt_nx = win_cnt;
        if (force_off) begin
            state_nx   = G_HALT;
            win_cnt_nx = '0;
        end else begin
            unique case (state)
                G_HALT: begin
                    win_cnt_nx = '0;
                    state_nx   = stop_req ? G_STOP : G_MIN;
                end
                G_MIN: begin
                    if (win_cnt == LAST) begin
                        state_nx = stop_req ? G_STOP : G_RUN;
                    end else begin
                        win_cnt_nx = win_cnt + 1'b1;
                    end
                end
                G_RUN: begin
                    if (stop_req) state_nx = G_STOP;
                end
                G_STOP: begin
                    if (!stop_req) begin
                        state_nx   = G_MIN;
                        win_cnt_nx = '0;
                    end
                end
                default: state_nx = G_HALT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            G_MIN, G_RUN: run_nx = 1'b1;
            default:      run_nx = 1'b0;
        endcase
        parked = (state == G_HALT) && !gate_en;
    end

    // Enable changes only while the source clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_en <= 1'b0;
        else        gate_en <= run_nx;
    end

endmodule

// File: rtl/clkstop_pwrseq.sv
module clkstop_pwrseq
    import clkstop_pkg::*;
#(
    parameter int STAB_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic cpu_parked,
    input  logic pci_parked,
    output logic allow,
    output logic osc_en,
    output logic vco_en,
    output logic ref_en
);

    localparam int CW = $clog2(STAB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    pwr_state_t state, state_nx;
    logic [CW-1:0] stab_cnt, stab_cnt_nx;
    logic osc_on;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= P_WAKE;
            stab_cnt <= '0;
        end else begin
            state    <= state_nx;
            stab_cnt <= stab_cnt_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx    = state;
        stab_cnt_nx = stab_cnt;
        unique case (state)
            P_WAKE: begin
                if (pd_req) begin
                    state_nx = P_PARK;
                end else if (stab_cnt == LAST) begin
                    state_nx = P_RUN;
                end else begin
                    stab_cnt_nx = stab_cnt + 1'b1;
                end
            end
            P_RUN: begin
                if (pd_req) state_nx = P_PARK;
            end
            P_PARK: begin
                if (cpu_parked && pci_parked) state_nx = P_OFF;
            end
            P_OFF: begin
                if (!pd_req) begin
                    state_nx    = P_WAKE;
                    stab_cnt_nx = '0;
                end
            end
            default: state_nx = P_WAKE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            P_RUN: begin
                allow  = 1'b1;
                osc_on = 1'b1;
            end
            P_OFF: begin
                allow  = 1'b0;
                osc_on = 1'b0;
            end
            default: begin
                allow  = 1'b0;
                osc_on = 1'b1;
            end
        endcase
        osc_en = osc_on;
        vco_en = osc_on;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) ref_en <= 1'b1;
        else        ref_en <= osc_on;
    end

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
    parameter int N_CPU         = 2,
    parameter int N_PCI         = 5,
    parameter int CPU_MIN_ON    = 100,
    parameter int PCI_MIN_ON    = 10,
    parameter int STAB_CYCLES   = 32,
    parameter int CPU_SYNC      = 2,
    parameter int PCI_STOP_SYNC = 0,
    parameter int PD_SYNC       = 2
) (
    input  logic             cpu_clk_in,
    input  logic             pci_clk_in,
    input  logic             ref_clk_in,
    input  logic             rst_n,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_dn_n,
    output logic [N_CPU-1:0] cpu_clk_out,
    output logic [N_PCI-1:0] pci_clk_out,
    output logic             pci_free_out,
    output logic             ref_out,
    output logic             osc_en,
    output logic             vco_en
);

    logic allow;
    logic ref_en;

    // Processor domain
    logic cpu_stop_s, cpu_pd_s, cpu_allow_s, cpu_force, cpu_en, cpu_parked;

    clkstop_sync #(.STAGES(CPU_SYNC), .RST_VAL(1'b1)) u_sync_cpu_stop (
        .clk(cpu_clk_in), .rst_n(rst_n), .d(cpu_stop_n), .q(cpu_stop_s));
    clkstop_sync #(.STAGES(PD_SYNC), .RST_VAL(1'b0)) u_sync_cpu_pd (
        .clk(cpu_clk_in), .rst_n(rst_n), .d(pwr_dn_n), .q(cpu_pd_s));
    clkstop_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_cpu_allow (
        .clk(cpu_clk_in), .rst_n(rst_n), .d(allow), .q(cpu_allow_s));

    assign cpu_force = !cpu_pd_s || !cpu_allow_s;

    clkstop_gate #(.MIN_ON(CPU_MIN_ON)) u_gate_cpu (
        .clk(cpu_clk_in), .rst_n(rst_n), .stop_req(!cpu_stop_s),
        .force_off(cpu_force), .gate_en(cpu_en), .parked(cpu_parked));

    // Bus domain
    logic pci_stop_s, pci_pd_s, pci_allow_s, pci_force, pci_en, pci_parked;

    clkstop_sync #(.STAGES(PCI_STOP_SYNC), .RST_VAL(1'b1)) u_sync_pci_stop (
        .clk(pci_clk_in), .rst_n(rst_n), .d(pci_stop_n), .q(pci_stop_s));
    clkstop_sync #(.STAGES(PD_SYNC), .RST_VAL(1'b0)) u_sync_pci_pd (
        .clk(pci_clk_in), .rst_n(rst_n), .d(pwr_dn_n), .q(pci_pd_s));
    clkstop_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_pci_allow (
        .clk(pci_clk_in), .rst_n(rst_n), .d(allow), .q(pci_allow_s));

    assign pci_force = !pci_pd_s || !pci_allow_s;

    clkstop_gate #(.MIN_ON(PCI_MIN_ON)) u_gate_pci (
        .clk(pci_clk_in), .rst_n(rst_n), .stop_req(!pci_stop_s),
        .force_off(pci_force), .gate_en(pci_en), .parked(pci_parked));

    // Reference domain
    logic ref_pd_s, cpu_ack_s, pci_ack_s;

    clkstop_sync #(.STAGES(PD_SYNC), .RST_VAL(1'b1)) u_sync_ref_pd (
        .clk(ref_clk_in), .rst_n(rst_n), .d(pwr_dn_n), .q(ref_pd_s));
    clkstop_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_cpu_ack (
        .clk(ref_clk_in), .rst_n(rst_n), .d(cpu_parked), .q(cpu_ack_s));
    clkstop_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_pci_ack (
        .clk(ref_clk_in), .rst_n(rst_n), .d(pci_parked), .q(pci_ack_s));

    clkstop_pwrseq #(.STAB_CYCLES(STAB_CYCLES)) u_pwrseq (
        .clk(ref_clk_in), .rst_n(rst_n), .pd_req(!ref_pd_s),
        .cpu_parked(cpu_ack_s), .pci_parked(pci_ack_s),
        .allow(allow), .osc_en(osc_en), .vco_en(vco_en), .ref_en(ref_en));

    // Output gating
    generate
        for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_out
            assign cpu_clk_out[i] = cpu_clk_in & cpu_en;
        end
        for (genvar j = 0; j < N_PCI; j++) begin : g_pci_out
            assign pci_clk_out[j] = pci_clk_in & pci_en;
        end
    endgenerate

    assign pci_free_out = pci_clk_in;
    assign ref_out      = ref_clk_in & ref_en;

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
    parameter int CPU_MIN_ON = 100,
    parameter int PCI_MIN_ON = 10
) (
    input logic cpu_clk_in,
    input logic pci_clk_in,
    input logic ref_clk_in,
    input logic rst_n,
    input logic cpu_en,
    input logic pci_en,
    input logic cpu_force,
    input logic pci_force,
    input logic cpu_ack_s,
    input logic pci_ack_s,
    input logic osc_en
);

    localparam int CCW = $clog2(CPU_MIN_ON + 1);
    localparam int PCW = $clog2(PCI_MIN_ON + 1);

    logic [CCW-1:0] cpu_run;
    logic [PCW-1:0] pci_run;

    always_ff @(posedge cpu_clk_in or negedge rst_n) begin
        if (!rst_n)                           cpu_run <= '0;
        else if (!cpu_en)                     cpu_run <= '0;
        else if (cpu_run != CCW'(CPU_MIN_ON)) cpu_run <= cpu_run + 1'b1;
    end

    always_ff @(posedge pci_clk_in or negedge rst_n) begin
        if (!rst_n)                           pci_run <= '0;
        else if (!pci_en)                     pci_run <= '0;
        else if (pci_run != PCW'(PCI_MIN_ON)) pci_run <= pci_run + 1'b1;
    end

    AST_CPU_MIN_ON: assert property (@(posedge cpu_clk_in) disable iff (!rst_n)
        ($fell(cpu_en) && !$past(cpu_force)) |-> (cpu_run == CCW'(CPU_MIN_ON))) else $error("cpu min-on"); // R3

    AST_PCI_MIN_ON: assert property (@(posedge pci_clk_in) disable iff (!rst_n)
        ($fell(pci_en) && !$past(pci_force)) |-> (pci_run == PCW'(PCI_MIN_ON))) else $error("pci min-on"); // R5

    AST_CPU_FORCED_LOW: assert property (@(posedge cpu_clk_in) disable iff (!rst_n)
        $past(cpu_force) |-> !cpu_en) else $error("cpu not forced low"); // R8

    AST_PCI_FORCED_LOW: assert property (@(posedge pci_clk_in) disable iff (!rst_n)
        $past(pci_force) |-> !pci_en) else $error("pci not forced low"); // R8

    AST_ENABLES_AFTER_PARK: assert property (@(posedge ref_clk_in) disable iff (!rst_n)
        $fell(osc_en) |-> $past(cpu_ack_s && pci_ack_s)) else $error("osc off before park"); // R7

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
    .CPU_MIN_ON(CPU_MIN_ON),
    .PCI_MIN_ON(PCI_MIN_ON)
) u_chk (
    .cpu_clk_in(cpu_clk_in),
    .pci_clk_in(pci_clk_in),
    .ref_clk_in(ref_clk_in),
    .rst_n(rst_n),
    .cpu_en(cpu_en),
    .pci_en(pci_en),
    .cpu_force(cpu_force),
    .pci_force(pci_force),
    .cpu_ack_s(cpu_ack_s),
    .pci_ack_s(pci_ack_s),
    .osc_en(osc_en)
);

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps
module clkstop_ctrl_bench;

    localparam int N_CPU = 2;
    localparam int N_PCI = 5;
    localparam int CPU_MIN = 100;
    localparam int PCI_MIN = 10;
    localparam int STAB = 32;

    logic cpu_clk_in = 1'b0, pci_clk_in = 1'b0, ref_clk_in = 1'b0;
    logic rst_n = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic [N_CPU-1:0] cpu_clk_out;
    logic [N_PCI-1:0] pci_clk_out;
    logic pci_free_out, ref_out, osc_en, vco_en;

    always #2 cpu_clk_in = ~cpu_clk_in;   // 250 MHz
    always #6 pci_clk_in = ~pci_clk_in;
    always #7 ref_clk_in = ~ref_clk_in;

    clkstop_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .CPU_MIN_ON(CPU_MIN),
                   .PCI_MIN_ON(PCI_MIN), .STAB_CYCLES(STAB)) u_clkstop_ctrl (
        .cpu_clk_in(cpu_clk_in), .pci_clk_in(pci_clk_in), .ref_clk_in(ref_clk_in),
        .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .pwr_dn_n(pwr_dn_n), .cpu_clk_out(cpu_clk_out), .pci_clk_out(pci_clk_out),
        .pci_free_out(pci_free_out), .ref_out(ref_out), .osc_en(osc_en), .vco_en(vco_en));

    int n_chk = 0, n_fail = 0;
    int cpu_cnt = 0, pci_cnt = 0, ref_cnt = 0, free_cnt = 0;
    int cpu_werr = 0, pci_werr = 0, split_err = 0;
    int osc_fall_cpu = 0, osc_fall_pci = 0;
    realtime cpu_rise = 0.0, pci_rise = 0.0;
    bit done = 1'b0;

    // Pulse monitors
    always @(posedge cpu_clk_out[0]) begin cpu_cnt++; cpu_rise = $realtime; end
    always @(negedge cpu_clk_out[0]) if (($realtime - cpu_rise) < 1.99 || ($realtime - cpu_rise) > 2.01) cpu_werr++;
    always @(posedge pci_clk_out[0]) begin pci_cnt++; pci_rise = $realtime; end
    always @(negedge pci_clk_out[0]) if (($realtime - pci_rise) < 5.99 || ($realtime - pci_rise) > 6.01) pci_werr++;
    always @(posedge ref_out) ref_cnt++;
    always @(posedge pci_free_out) free_cnt++;
    always @(negedge osc_en) begin osc_fall_cpu = cpu_cnt; osc_fall_pci = pci_cnt; end
    always @(posedge cpu_clk_in) begin
        #1;
        if (!(cpu_clk_out == '0 || cpu_clk_out == '1) || !(pci_clk_out == '0 || pci_clk_out == '1)) split_err++;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        #20;
        check(cpu_clk_out == '0, "R10", "cpu outputs in reset", int'(cpu_clk_out), 0);
        check(pci_clk_out == '0, "R10", "pci outputs in reset", int'(pci_clk_out), 0);
        check(osc_en && vco_en, "R10", "osc/vco enables in reset", int'({osc_en, vco_en}), 3);
        #33 rst_n = 1'b1;
    endtask

    task automatic t_wake_after_reset();
        int c0 = cpu_cnt;
        int p0 = pci_cnt;
        #((STAB - 2) * 14);
        check(cpu_cnt == c0, "R9", "cpu pulses during stabilization", cpu_cnt - c0, 0);
        check(pci_cnt == p0, "R9", "pci pulses during stabilization", pci_cnt - p0, 0);
        #1000;
        check(cpu_cnt > c0, "R9", "cpu resumed after stabilization", cpu_cnt - c0, 1);
        check(pci_cnt > p0, "R9", "pci resumed after stabilization", pci_cnt - p0, 1);
    endtask

    task automatic t_cpu_stop();
        int c0, p0, k;
        @(negedge cpu_clk_in); #1;
        c0 = cpu_cnt;
        cpu_stop_n = 1'b0;
        #80;
        check(cpu_cnt - c0 == 3, "R2", "cpu pulses after stop", cpu_cnt - c0, 3);
        c0 = cpu_cnt; p0 = pci_cnt;
        #200;
        check(cpu_cnt == c0, "R1", "cpu held while stopped", cpu_cnt - c0, 0);
        check(cpu_clk_out == '0, "R1", "cpu output level while stopped", int'(cpu_clk_out), 0);
        check(pci_cnt - p0 >= 15, "R6", "pci running during cpu stop", pci_cnt - p0, 16);
        @(negedge cpu_clk_in); #1;
        c0 = cpu_cnt;
        cpu_stop_n = 1'b1;
        k = 0;
        for (int i = 1; i <= 10; i++) begin
            @(posedge cpu_clk_in); #1;
            if (k == 0 && cpu_cnt != c0) k = i;
        end
        check(k == 4, "R2", "cpu restart edge", k, 4);
        cpu_stop_n = 1'b0;                     // arrives inside the min-on window
        #800;
        check(cpu_cnt - c0 == CPU_MIN, "R3", "cpu pulses with pending stop", cpu_cnt - c0, CPU_MIN);
        cpu_stop_n = 1'b1;
        #800;
    endtask

    task automatic t_pci_stop();
        int p0, c0, f0, r0, k;
        @(negedge pci_clk_in); #1;
        p0 = pci_cnt; c0 = cpu_cnt; f0 = free_cnt; r0 = ref_cnt;
        pci_stop_n = 1'b0;
        #120;
        check(pci_cnt - p0 == 1, "R4", "pci pulses after stop", pci_cnt - p0, 1);
        check(free_cnt - f0 == 10, "R6", "free pci during pci stop", free_cnt - f0, 10);
        check(cpu_cnt - c0 == 30, "R6", "cpu during pci stop", cpu_cnt - c0, 30);
        check(ref_cnt - r0 >= 8, "R6", "ref during pci stop", ref_cnt - r0, 8);
        check(pci_clk_out == '0, "R1", "pci output level while stopped", int'(pci_clk_out), 0);
        @(negedge pci_clk_in); #1;
        p0 = pci_cnt;
        pci_stop_n = 1'b1;
        k = 0;
        for (int i = 1; i <= 4; i++) begin
            @(posedge pci_clk_in); #1;
            if (k == 0 && pci_cnt != p0) k = i;
        end
        check(k == 2, "R4", "pci restart edge", k, 2);
        pci_stop_n = 1'b0;                     // inside the min-on window
        #300;
        check(pci_cnt - p0 == PCI_MIN, "R5", "pci pulses with pending stop", pci_cnt - p0, PCI_MIN);
        pci_stop_n = 1'b1;
        #300;
    endtask

    task automatic t_power_down();
        int c0, p0, r0;
        @(negedge cpu_clk_in); #1;
        c0 = cpu_cnt; p0 = pci_cnt;
        pwr_dn_n = 1'b0;
        #400;
        check(cpu_cnt - c0 <= 3, "R7", "cpu pulses after power-down", cpu_cnt - c0, 3);
        check(pci_cnt - p0 <= 3, "R7", "pci pulses after power-down", pci_cnt - p0, 3);
        check(!osc_en && !vco_en, "R7", "osc/vco enables off", int'({osc_en, vco_en}), 0);
        check(osc_fall_cpu == cpu_cnt && osc_fall_pci == pci_cnt, "R7", "pulses after enables fell",
              (cpu_cnt - osc_fall_cpu) + (pci_cnt - osc_fall_pci), 0);
        r0 = ref_cnt;
        #200;
        check(ref_cnt == r0, "R7", "ref stopped in power-down", ref_cnt - r0, 0);
        c0 = cpu_cnt; p0 = pci_cnt;
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        #150;
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        #300;
        check(cpu_cnt == c0 && pci_cnt == p0, "R8", "gated pulses while powered down",
              (cpu_cnt - c0) + (pci_cnt - p0), 0);
        check(cpu_clk_out == '0 && pci_clk_out == '0, "R8", "outputs low while powered down",
              int'(cpu_clk_out) + int'(pci_clk_out), 0);
        pwr_dn_n = 1'b1;
        wait (osc_en === 1'b1);
        c0 = cpu_cnt; p0 = pci_cnt; r0 = ref_cnt;
        check(vco_en, "R9", "vco enable on wake", int'(vco_en), 1);
        #((STAB - 2) * 14);
        check(cpu_cnt == c0 && pci_cnt == p0, "R9", "pulses during wake stabilization",
              (cpu_cnt - c0) + (pci_cnt - p0), 0);
        #800;
        check(cpu_cnt > c0 && pci_cnt > p0, "R9", "clocks resumed after wake", cpu_cnt - c0, 1);
        check(ref_cnt > r0, "R9", "ref resumed after wake", ref_cnt - r0, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_wake_after_reset();
        #500;
        t_cpu_stop();
        t_pci_stop();
        t_power_down();
        check(cpu_werr == 0 && pci_werr == 0, "R1", "short high pulses", cpu_werr + pci_werr, 0);
        check(split_err == 0, "R1", "outputs of one family disagree", split_err, 0);
        finish_run();
    end

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule